// File: doc/BRIEF.md
# Bus Traffic Performance Counter Unit

This block watches one port of an on-chip bus and counts how busy the port is. It holds one cycle counter and four event counters. The monitored port supplies one single-cycle strobe for each read data beat and one for each write data beat. Each event counter has its own type select, which picks read beats, write beats or both. When both are picked, a read beat and a write beat in the same cycle add two. Event counter 3 is wider than the others, so it can run over long windows without wrapping.

Software works the unit through a 32-bit register port with single-cycle writes and combinational reads. To measure an interval, software does the following. It turns on the counters it needs through a write-one-to-set register. It chooses the event types. It clears the counts through the self-clearing reset bits in the control register. It sets the global run bit. At the end of the window it clears the run bit, so that every count stops on the same edge, and reads a coherent snapshot at its own pace.

A counter that wraps past its all-ones value raises a sticky overflow flag. Software clears the flag by writing a one to it. A single level interrupt output is raised by any flag whose mask bit is set.

Top module: `pmu_traffic_mon`

## Requirements
- R1: After reset every register reads 0, all counts are 0 and `irq` is low.
- R2: The enable masks use bit 31 for the cycle counter and bits 3..0 for event counters 3..0. A write to 0x10 sets the enables whose mask bits are 1, and a write to 0x20 clears them. Mask bits that are 0 leave their enables unchanged. Both addresses read back the current enables in the same layout.
- R3: The control register at 0x00 has the run bit at bit 0 and the start-mode field at bits 5:4. Start mode 0 is manual, and every other value is reserved. Counting happens only when run is 1 and the start mode is 0. Otherwise all counts hold their values.
- R4: Control bit 1 zeroes all event counters and control bit 2 zeroes the cycle counter and its prescaler. The counts read 0 after the edge that takes the write. Both bits always read back as 0.
- R5: The event type register of counter i is at 0x80+4*i, with the type in bits 1:0. The codes are: 0 counts nothing, 1 counts read beats, 2 counts write beats, 3 counts both. With code 3, a read beat and a write beat in the same cycle add 2.
- R6: The cycle counter reads at 0x50. When control bit 3 is 0 it adds 1 on every enabled clock. When bit 3 is 1 it adds 1 once every 2^DIV_LOG2 enabled clocks (64 by default).
- R7: Event counters 0..2 are CNT_W bits wide (32 by default) and read at 0x60, 0x64 and 0x68. Counter 3 is WIDE_W bits wide (40 by default). Its low CNT_W bits read at 0x6C and its upper bits read at 0x70, right-aligned and zero-filled above.
- R8: When a counter wraps past its all-ones value, its flag is set in the register at 0x30, which uses the R2 bit layout. Writing ones to 0x30 clears the selected flags. A wrap on the same edge wins over the clear.
- R9: Writing ones to 0x40 (R2 bit layout) zeroes the selected counters. A zeroing wins over an increment on the same edge and raises no flag. The register reads 0.
- R10: The interrupt mask is at 0x90 in the R2 bit layout. `irq` is high exactly when some flag and its mask bit are both 1.
- R11: Reads return the current register state in the same cycle, and any other address reads 0. Writes to unused addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Byte address of the register being read or written |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| rd_beat | input | 1 | One read data beat seen on the monitored port this cycle |
| wr_beat | input | 1 | One write data beat seen on the monitored port this cycle |
| irq | output | 1 | Level interrupt: any masked overflow flag |

## Verification
A write, a beat strobe and a wrap all take effect on the rising edge that samples them. The new value is visible on `reg_rdata` for the same address, and on `irq`, right after that edge. No extra pipeline stage sits in between. The bench therefore drives each cycle's inputs, lets one rising edge pass, and steps its behavioural model for that edge. At the following falling edge it compares the read data for the address still on the bus, and the interrupt level, against the model. Overflows and the divided cycle count are reached by building the bench with narrow counters and a short prescaler, so wraps of both counter widths occur within the run.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    localparam int NUM_EVT = 4;
    localparam int NUM_CTR = NUM_EVT + 1;
    localparam int CYC_IDX = NUM_EVT;
    localparam int ADDR_W  = 8;

    localparam logic [ADDR_W-1:0] A_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] A_ENSET = 8'h10;
    localparam logic [ADDR_W-1:0] A_ENCLR = 8'h20;
    localparam logic [ADDR_W-1:0] A_FLAG  = 8'h30;
    localparam logic [ADDR_W-1:0] A_CRST  = 8'h40;
    localparam logic [ADDR_W-1:0] A_CYC   = 8'h50;
    localparam logic [ADDR_W-1:0] A_EVT0  = 8'h60;
    localparam logic [ADDR_W-1:0] A_EVTHI = 8'h70;
    localparam logic [ADDR_W-1:0] A_TYPE0 = 8'h80;
    localparam logic [ADDR_W-1:0] A_IEN   = 8'h90;

    localparam logic [1:0] MODE_MANUAL = 2'd0;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_RD   = 2'd1,
        EV_WR   = 2'd2,
        EV_RW   = 2'd3
    } ev_type_e;

    typedef struct packed {
        logic [1:0] mode;
        logic       slow;
        logic       run;
    } ctrl_t;
endpackage

// File: rtl/pm_event_ctr.sv
module pm_event_ctr
    import pmu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         count_en,
    input  logic         clear,
    input  ev_type_e     sel,
    input  logic         rd_beat,
    input  logic         wr_beat,
    output logic [W-1:0] value,
    output logic         wrap
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } state_t;

    state_t     state_d, state_q;
    logic [1:0] step;
    logic [W:0] sum;

    always_comb begin
        step = 2'd0;
        if (sel == EV_RD || sel == EV_RW) step = step + {1'b0, rd_beat};
        if (sel == EV_WR || sel == EV_RW) step = step + {1'b0, wr_beat};
        sum     = {1'b0, state_q.cnt} + (W+1)'(step);
        state_d = state_q;
        wrap    = 1'b0;
        if (clear) begin
            state_d.cnt = '0;
        end else if (count_en) begin
            state_d.cnt = sum[W-1:0];
            wrap        = sum[W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign value = state_q.cnt;

    // R3: a counter that is not enabled keeps its value
    a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !clear) |=> $stable(state_q.cnt));

    // R5: one edge adds at most two beats
    a_r5_step_at_most_two: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (W'(state_q.cnt - $past(state_q.cnt)) <= W'(2)));
endmodule

// File: rtl/pm_cycle_ctr.sv
module pm_cycle_ctr #(
    parameter int W        = 32,
    parameter int DIV_LOG2 = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         count_en,
    input  logic         slow,
    input  logic         clear,
    output logic [W-1:0] value,
    output logic         wrap
);
    typedef struct packed {
        logic [W-1:0]        cnt;
        logic [DIV_LOG2-1:0] pre;
    } state_t;

    state_t state_d, state_q;
    logic   tick;

    always_comb begin
        state_d = state_q;
        wrap    = 1'b0;
        tick    = !slow || (&state_q.pre);
        if (clear) begin
            state_d.cnt = '0;
            state_d.pre = '0;
        end else if (count_en) begin
            if (slow) state_d.pre = state_q.pre + 1'b1;
            if (tick) begin
                state_d.cnt = state_q.cnt + 1'b1;
                wrap        = &state_q.cnt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign value = state_q.cnt;

    // R6: the cycle count never moves by more than one per edge
    a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (state_q.cnt == $past(state_q.cnt) || state_q.cnt == $past(state_q.cnt) + 1'b1));

    // R6: in divided mode, only the last prescaler step advances the count
    a_r6_divided_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (slow && !clear && !(&state_q.pre)) |=> $stable(state_q.cnt));
endmodule

// File: rtl/pmu_traffic_mon.sv
module pmu_traffic_mon
    import pmu_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int WIDE_W   = 40,
    parameter int DIV_LOG2 = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              rd_beat,
    input  logic              wr_beat,
    output logic              irq
);
    localparam int HI_W = WIDE_W - CNT_W;

    typedef struct packed {
        ctrl_t                     ctrl;
        logic [NUM_CTR-1:0]        en;
        logic [NUM_CTR-1:0]        flag;
        logic [NUM_CTR-1:0]        ien;
        logic [NUM_EVT-1:0][1:0]   typ;
    } regs_t;

    regs_t              regs_d, regs_q;
    logic               active;
    logic [NUM_CTR-1:0] wmask;
    logic [NUM_CTR-1:0] clr_vec;
    logic [NUM_CTR-1:0] wrap_vec;
    logic               hit_ctrl, hit_set, hit_clr, hit_flag, hit_crst, hit_ien;
    logic [CNT_W-1:0]   cyc_val;
    logic [WIDE_W-1:0]  ev_val [NUM_EVT];

    always_comb begin
        active   = regs_q.ctrl.run && (regs_q.ctrl.mode == MODE_MANUAL);
        wmask    = {reg_wdata[31], reg_wdata[NUM_EVT-1:0]};
        hit_ctrl = reg_we && (reg_addr == A_CTRL);
        hit_set  = reg_we && (reg_addr == A_ENSET);
        hit_clr  = reg_we && (reg_addr == A_ENCLR);
        hit_flag = reg_we && (reg_addr == A_FLAG);
        hit_crst = reg_we && (reg_addr == A_CRST);
        hit_ien  = reg_we && (reg_addr == A_IEN);
        for (int i = 0; i < NUM_EVT; i++) begin
            clr_vec[i] = (hit_ctrl && reg_wdata[1]) || (hit_crst && reg_wdata[i]);
        end
        clr_vec[CYC_IDX] = (hit_ctrl && reg_wdata[2]) || (hit_crst && reg_wdata[31]);
    end

    always_comb begin
        regs_d = regs_q;
        if (hit_ctrl) begin
            regs_d.ctrl.run  = reg_wdata[0];
            regs_d.ctrl.slow = reg_wdata[3];
            regs_d.ctrl.mode = reg_wdata[5:4];
        end
        if (hit_set) regs_d.en = regs_q.en | wmask;
        if (hit_clr) regs_d.en = regs_q.en & ~wmask;
        if (hit_ien) regs_d.ien = wmask;
        regs_d.flag = (regs_q.flag & ~(hit_flag ? wmask : '0)) | wrap_vec;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (reg_we && reg_addr == A_TYPE0 + ADDR_W'(4 * i)) regs_d.typ[i] = reg_wdata[1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    pm_cycle_ctr #(.W(CNT_W), .DIV_LOG2(DIV_LOG2)) u_cyc (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (active && regs_q.en[CYC_IDX]),
        .slow     (regs_q.ctrl.slow),
        .clear    (clr_vec[CYC_IDX]),
        .value    (cyc_val),
        .wrap     (wrap_vec[CYC_IDX])
    );

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        localparam int GW = (g == NUM_EVT - 1) ? WIDE_W : CNT_W;
        logic [GW-1:0] val;
        pm_event_ctr #(.W(GW)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .count_en (active && regs_q.en[g]),
            .clear    (clr_vec[g]),
            .sel      (ev_type_e'(regs_q.typ[g])),
            .rd_beat  (rd_beat),
            .wr_beat  (wr_beat),
            .value    (val),
            .wrap     (wrap_vec[g])
        );
        assign ev_val[g] = WIDE_W'(val);
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL:           reg_rdata = {26'd0, regs_q.ctrl.mode, regs_q.ctrl.slow, 2'b00, regs_q.ctrl.run};
            A_ENSET, A_ENCLR: reg_rdata = {regs_q.en[CYC_IDX], 27'd0, regs_q.en[NUM_EVT-1:0]};
            A_FLAG:           reg_rdata = {regs_q.flag[CYC_IDX], 27'd0, regs_q.flag[NUM_EVT-1:0]};
            A_IEN:            reg_rdata = {regs_q.ien[CYC_IDX], 27'd0, regs_q.ien[NUM_EVT-1:0]};
            A_CYC:            reg_rdata = 32'(cyc_val);
            A_EVTHI:          reg_rdata = 32'(ev_val[NUM_EVT-1][WIDE_W-1:CNT_W]);
            default:          reg_rdata = '0;
        endcase
        for (int i = 0; i < NUM_EVT; i++) begin
            if (reg_addr == A_EVT0 + ADDR_W'(4 * i))  reg_rdata = 32'(ev_val[i][CNT_W-1:0]);
            if (reg_addr == A_TYPE0 + ADDR_W'(4 * i)) reg_rdata = 32'(regs_q.typ[i]);
        end
    end

    assign irq = |(regs_q.flag & regs_q.ien);

    logic unused_bits;
    assign unused_bits = ^{reg_wdata, ev_val[0], ev_val[1], ev_val[2], HI_W[0]};

    // R2: set bits are on after a set write
    a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
        hit_set |=> ((regs_q.en & $past(wmask)) == $past(wmask)));

    // R2: cleared bits are off after a clear write
    a_r2_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        hit_clr |=> ((regs_q.en & $past(wmask)) == '0));

    // R3: with counting stopped and no reset written, the cycle count holds
    a_r3_frozen_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !hit_ctrl && !hit_crst) |=> $stable(cyc_val));

    // R4: the control cycle-reset bit zeroes the cycle count
    a_r4_cycle_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_ctrl && reg_wdata[2]) |=> (cyc_val == '0));

    // R9: the counter-reset register zeroes event counter 0
    a_r9_evt0_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_crst && reg_wdata[0]) |=> (ev_val[0] == '0));

    // R8: a flag that is not cleared stays set
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((regs_q.flag & $past(regs_q.flag & ~(hit_flag ? wmask : '0)))
                  == $past(regs_q.flag & ~(hit_flag ? wmask : '0))));

    // R10: the interrupt needs a pending flag
    a_r10_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|regs_q.flag));
endmodule

// File: tb/pmu_traffic_mon_test.sv
module pmu_traffic_mon_test;
    localparam int CW = 10;
    localparam int WW = 14;
    localparam int DL = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        rd_beat = 1'b0;
    logic        wr_beat = 1'b0;
    logic        irq;

    always #2 clk = ~clk;

    pmu_traffic_mon #(.CNT_W(CW), .WIDE_W(WW), .DIV_LOG2(DL)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .rd_beat   (rd_beat),
        .wr_beat   (wr_beat),
        .irq       (irq)
    );

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    bit         m_run, m_div;
    int         m_mode;
    bit [4:0]   m_en, m_flag, m_ien;
    int         m_typ [4];
    longint     m_cnt [4];
    longint     m_cyc;
    int         m_pre;

    bit [7:0] addrs [15] = '{8'h00, 8'h10, 8'h20, 8'h30, 8'h40, 8'h50, 8'h60, 8'h64,
                             8'h68, 8'h6C, 8'h70, 8'h80, 8'h84, 8'h88, 8'h90};

    function automatic longint lim(int i);
        return (i == 3) ? (64'd1 << WW) : (64'd1 << CW);
    endfunction

    function automatic bit [31:0] m_read(bit [7:0] a);
        case (a)
            8'h00: return {26'd0, 2'(m_mode), m_div, 2'b00, m_run};
            8'h10, 8'h20: return {m_en[4], 27'd0, m_en[3:0]};
            8'h30: return {m_flag[4], 27'd0, m_flag[3:0]};
            8'h90: return {m_ien[4], 27'd0, m_ien[3:0]};
            8'h50: return 32'(m_cyc);
            8'h60: return 32'(m_cnt[0]);
            8'h64: return 32'(m_cnt[1]);
            8'h68: return 32'(m_cnt[2]);
            8'h6C: return 32'(m_cnt[3] % (64'd1 << CW));
            8'h70: return 32'(m_cnt[3] >> CW);
            8'h80: return 32'(m_typ[0]);
            8'h84: return 32'(m_typ[1]);
            8'h88: return 32'(m_typ[2]);
            8'h8C: return 32'(m_typ[3]);
            default: return 32'd0;
        endcase
    endfunction

    task automatic m_reset();
        m_run = 0; m_div = 0; m_mode = 0; m_en = 0; m_flag = 0; m_ien = 0;
        m_cyc = 0; m_pre = 0;
        for (int i = 0; i < 4; i++) begin
            m_typ[i] = 0;
            m_cnt[i] = 0;
        end
    endtask

    task automatic m_step(bit we, bit [7:0] a, bit [31:0] d, bit rb, bit wb);
        bit       act;
        bit [4:0] wrapv;
        bit [4:0] wm;
        longint   ncnt [4];
        longint   ncyc;
        int       npre;
        act   = m_run && (m_mode == 0);
        wrapv = 0;
        ncyc  = m_cyc;
        npre  = m_pre;
        wm    = {d[31], d[3:0]};
        for (int i = 0; i < 4; i++) begin
            ncnt[i] = m_cnt[i];
            if (act && m_en[i]) begin
                int dd = 0;
                if ((m_typ[i] & 1) != 0 && rb) dd++;
                if ((m_typ[i] & 2) != 0 && wb) dd++;
                ncnt[i] = m_cnt[i] + dd;
                if (ncnt[i] >= lim(i)) begin
                    ncnt[i] -= lim(i);
                    wrapv[i] = 1;
                end
            end
        end
        if (act && m_en[4]) begin
            bit tk = !m_div || (m_pre == (1 << DL) - 1);
            if (m_div) npre = (m_pre + 1) % (1 << DL);
            if (tk) begin
                ncyc = m_cyc + 1;
                if (ncyc >= (64'd1 << CW)) begin
                    ncyc = 0;
                    wrapv[4] = 1;
                end
            end
        end
        if (we) begin
            case (a)
                8'h00: begin
                    m_run = d[0]; m_div = d[3]; m_mode = int'(d[5:4]);
                    if (d[1]) for (int i = 0; i < 4; i++) begin ncnt[i] = 0; wrapv[i] = 0; end
                    if (d[2]) begin ncyc = 0; npre = 0; wrapv[4] = 0; end
                end
                8'h10: m_en = m_en | wm;
                8'h20: m_en = m_en & ~wm;
                8'h30: m_flag = m_flag & ~wm;
                8'h40: begin
                    for (int i = 0; i < 4; i++) if (wm[i]) begin ncnt[i] = 0; wrapv[i] = 0; end
                    if (wm[4]) begin ncyc = 0; npre = 0; wrapv[4] = 0; end
                end
                8'h80: m_typ[0] = int'(d[1:0]);
                8'h84: m_typ[1] = int'(d[1:0]);
                8'h88: m_typ[2] = int'(d[1:0]);
                8'h8C: m_typ[3] = int'(d[1:0]);
                8'h90: m_ien = wm;
                default: ;
            endcase
        end
        m_flag = m_flag | wrapv;
        for (int i = 0; i < 4; i++) m_cnt[i] = ncnt[i];
        m_cyc = ncyc;
        m_pre = npre;
    endtask

    task automatic compare(string tag);
        bit [31:0] exp_d;
        bit        exp_i;
        exp_d = m_read(reg_addr);
        exp_i = |(m_flag & m_ien);
        vectors++;
        if (reg_rdata !== exp_d) begin
            errors++;
            $display("FAIL %s addr=%02h rdata actual=%08h expected=%08h", tag, reg_addr, reg_rdata, exp_d);
        end
        vectors++;
        if (irq !== exp_i) begin
            errors++;
            $display("FAIL R10 (%s) irq actual=%0b expected=%0b", tag, irq, exp_i);
        end
    endtask

    task automatic cyc(bit we, bit [7:0] a, bit [31:0] d, bit rb, bit wb, string tag);
        reg_we = we; reg_addr = a; reg_wdata = d; rd_beat = rb; wr_beat = wb;
        @(posedge clk);
        m_step(we, a, d, rb, wb);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic scan(string tag, bit beats);
        foreach (addrs[k]) begin
            cyc(0, addrs[k], 32'd0, beats & 1'($urandom), beats & 1'($urandom), tag);
        end
    endtask

    task automatic idle(int n, bit [7:0] a, bit rb, bit wb, string tag);
        for (int k = 0; k < n; k++) cyc(0, a, 32'd0, rb, wb, tag);
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1");
        scan("R1", 0);

        // R2: set and clear with partial masks
        cyc(1, 8'h10, 32'h8000_0003, 0, 0, "R2");
        scan("R2", 0);
        cyc(1, 8'h20, 32'h0000_0001, 0, 0, "R2");
        cyc(0, 8'h20, 32'd0, 0, 0, "R2");
        cyc(1, 8'h10, 32'h8000_000F, 0, 0, "R2");
        cyc(0, 8'h10, 32'd0, 0, 0, "R2");

        // R5: one counter per type code
        cyc(1, 8'h80, 32'h1, 0, 0, "R5");
        cyc(1, 8'h84, 32'h2, 0, 0, "R5");
        cyc(1, 8'h88, 32'h3, 0, 0, "R5");
        cyc(1, 8'h8C, 32'hFFFF_FFFF, 0, 0, "R5");
        scan("R5", 0);

        // R3: run in manual mode, several beat patterns
        cyc(1, 8'h00, 32'h1, 0, 0, "R3");
        idle(6, 8'h68, 1, 1, "R5");
        idle(6, 8'h60, 1, 0, "R5");
        idle(6, 8'h64, 0, 1, "R5");
        for (int k = 0; k < 40; k++) cyc(0, addrs[k % 15], 32'd0, 1'($urandom), 1'($urandom), "R7");

        // R3: frozen snapshot, then reserved start mode
        cyc(1, 8'h00, 32'h0, 1, 1, "R3");
        idle(8, 8'h50, 1, 1, "R3");
        scan("R3", 1);
        cyc(1, 8'h00, 32'h11, 1, 1, "R3");
        idle(8, 8'h68, 1, 1, "R3");
        scan("R3", 1);

        // R6: divided cycle counting
        cyc(1, 8'h00, 32'h9, 0, 0, "R6");
        idle(40, 8'h50, 0, 0, "R6");
        cyc(1, 8'h00, 32'h1, 0, 0, "R6");
        idle(10, 8'h50, 0, 0, "R6");

        // R4: self-clearing reset bits
        cyc(1, 8'h00, 32'h7, 1, 1, "R4");
        cyc(0, 8'h00, 32'd0, 0, 0, "R4");
        scan("R4", 1);

        // R9: counter-reset register, with beats in the same cycle
        idle(5, 8'h68, 1, 1, "R9");
        cyc(1, 8'h40, 32'h8000_0004, 1, 1, "R9");
        cyc(0, 8'h68, 32'd0, 0, 0, "R9");
        cyc(0, 8'h50, 32'd0, 0, 0, "R9");
        scan("R9", 1);

        // R8, R10: wraps of the narrow and wide counters
        cyc(1, 8'h90, 32'h8000_0004, 0, 0, "R10");
        cyc(1, 8'h00, 32'h3, 0, 0, "R8");
        for (int k = 0; k < 9000; k++) begin
            if (k % 700 == 699) cyc(1, 8'h30, 32'hFFFF_FFFF, 1, 1, "R8");
            else cyc(0, (k % 8 == 0) ? 8'h70 : ((k % 8 == 1) ? 8'h6C : 8'h30), 32'd0, 1, 1, "R8");
        end
        scan("R8", 1);
        cyc(1, 8'h30, 32'h8000_000F, 0, 0, "R8");
        cyc(1, 8'h90, 32'h8000_000F, 0, 0, "R10");

        // R11: random register traffic mixed with beats
        for (int k = 0; k < 4000; k++) begin
            bit [7:0]  a;
            bit [31:0] d;
            bit        we;
            we = ($urandom % 4) == 0;
            a  = ($urandom % 16 == 0) ? 8'(($urandom % 64) * 4) : addrs[$urandom % 15];
            d  = $urandom;
            if (a == 8'h00 && ($urandom % 4) != 0) begin
                d[5:4] = 2'b00;
                d[0]   = 1'b1;
            end
            if (a == 8'h40 || (a == 8'h00 && ($urandom % 8) != 0)) d[2:1] = 2'b00;
            cyc(we, a, d, 1'($urandom), 1'($urandom), "R11");
        end
        scan("R11", 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule